// File: doc/BRIEF.md
# Receive Byte Queue with Fill Trigger and Idle Timeout

This block buffers received bytes for a serial port between an already-deserialized receive path and a CPU. Bytes come in on a valid/data pair. The CPU side pops them with a read strobe and can see how many bytes are waiting. A 2-bit select picks a fill threshold. When the queue reaches that threshold, a data-full flag goes high and, if enabled, so does a receive interrupt.

If the queue holds fewer bytes than the threshold and stays idle, the flag rises anyway after fifteen character times. Character times are counted on a supplied one-cycle tick. This keeps a short message from being stranded below a high threshold. A synchronous clear input empties the queue. Bytes are taken in only while the receiver-enable input is high.

Top module: `rx_trig_fifo`

## Requirements
- R1: After reset the queue is empty: `fill_count` is 0, `data_full` and `rx_irq` are low, and `rd_data` is 0.
- R2: Bytes leave in arrival order. While the queue is not empty, `rd_data` shows the oldest byte, and a `rd_strobe` pulse removes it; order is kept across pointer wraparound past entry 15.
- R3: A byte offered while 16 bytes are held is dropped, and `fill_count` stays 16.
- R4: A byte offered while `rx_en` is low is dropped.
- R5: `trig_sel` selects the threshold: 0 gives 1 byte, 1 gives 4, 2 gives 8, 3 gives 14. `data_full` is high from the cycle after a push that brings `fill_count` to at least the threshold.
- R6: A read that leaves `fill_count` below the threshold clears `data_full` in the next cycle.
- R7: A push that leaves `fill_count` below the threshold restarts the idle timer. On the fifteenth `char_tick` after the latest restart, `data_full` rises in the next cycle.
- R8: `rx_irq` rises with a threshold or timeout event only while `rx_irq_en` is high. It drops in the cycle after `rx_irq_en` goes low or after `data_full` is cleared.
- R9: `fifo_clr` empties the queue, clears `data_full` and `rx_irq`, and stops the timer. It overrides a push or read in the same cycle.
- R10: A read strobe on an empty queue leaves all state unchanged, and `rd_data` reads 0.
- R11: A push and a read in the same cycle leave `fill_count` unchanged and keep byte order.
- R12: A push that reaches the threshold while `rx_irq_en` is high cancels a running idle timer, so a later drop below the threshold followed by fifteen ticks does not raise `data_full`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receiver enable; gates incoming bytes |
| in_valid | input | 1 | Incoming byte present |
| in_data | input | 8 | Incoming byte |
| char_tick | input | 1 | One-cycle pulse per character time |
| rd_strobe | input | 1 | Pop the oldest byte |
| rd_data | output | 8 | Oldest byte, 0 when empty |
| fill_count | output | 5 | Bytes held |
| fifo_clr | input | 1 | Synchronous queue clear |
| trig_sel | input | 2 | Threshold select |
| rx_irq_en | input | 1 | Receive interrupt enable |
| data_full | output | 1 | Threshold reached or idle timeout |
| rx_irq | output | 1 | Receive interrupt |

## Verification
The bench checks the flag exactly at each threshold boundary. A design that compared with the wrong sense or used the wrong level would raise the flag one byte early or late. It counts ticks to the fourteenth and fifteenth, so an off-by-one timer is caught, and it restarts the timer mid-count to catch a design that never reloads. The bench also fills the queue after moving the pointers, which exposes broken wraparound or a count that overflows. Finally, it checks that a threshold hit cancels the timer, that a clear takes priority over a simultaneous push, and that an empty read has no effect.

// File: rtl/rx_trig_fifo_pkg.sv
package rx_trig_fifo_pkg;

   localparam int unsigned MAX_TRIG = 14;

   // Threshold select decode; the ordering is part of the register contract.
   function automatic int unsigned trig_level(input logic [1:0] sel);
      case (sel)
         2'd0:    return 1;
         2'd1:    return 4;
         2'd2:    return 8;
         default: return MAX_TRIG;
      endcase
   endfunction

endpackage

// File: rtl/rx_trig_store.sv
module rx_trig_store #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DEPTH  = 16,
   localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              push,
   input  logic              pop,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] tail_data
);

   logic [DATA_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  head_q, tail_q;
   logic [PTR_W-1:0]  head_inc, tail_inc;

   localparam bit POW2 = (DEPTH == (1 << PTR_W));

   generate
      if (POW2) begin : g_wrap_natural
         assign head_inc = head_q + 1'b1;
         assign tail_inc = tail_q + 1'b1;
      end else begin : g_wrap_compare
         assign head_inc = (head_q == PTR_W'(DEPTH - 1)) ? '0 : head_q + 1'b1;
         assign tail_inc = (tail_q == PTR_W'(DEPTH - 1)) ? '0 : tail_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head_q <= '0;
         tail_q <= '0;
      end else if (clr) begin
         head_q <= '0;
         tail_q <= '0;
      end else begin
         if (push) head_q <= head_inc;
         if (pop)  tail_q <= tail_inc;
      end
   end

   always_ff @(posedge clk) begin
      if (push && !clr) mem[head_q] <= wdata;
   end

   assign tail_data = mem[tail_q];

   a_r2_ptr_range: assert property (@(posedge clk) disable iff (!rst_n)
      (head_q < PTR_W'(DEPTH)) || POW2);

endmodule

// File: rtl/rx_trig_timer.sv
module rx_trig_timer #(
   parameter int unsigned LIMIT = 15,
   localparam int unsigned CNT_W = $clog2(LIMIT + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic cancel,
   input  logic tick,
   output logic expire
);

   logic             armed_q;
   logic [CNT_W-1:0] ticks_q;
   logic             last_tick;

   assign last_tick = (ticks_q == CNT_W'(LIMIT - 1));
   assign expire    = armed_q && tick && last_tick && !restart && !cancel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         ticks_q <= '0;
      end else if (restart) begin
         armed_q <= 1'b1;
         ticks_q <= '0;
      end else if (cancel) begin
         armed_q <= 1'b0;
         ticks_q <= '0;
      end else if (armed_q && tick) begin
         if (last_tick) begin
            armed_q <= 1'b0;
            ticks_q <= '0;
         end else begin
            ticks_q <= ticks_q + 1'b1;
         end
      end
   end

   a_r7_count_range: assert property (@(posedge clk) disable iff (!rst_n)
      armed_q |-> (ticks_q < CNT_W'(LIMIT)));
   a_r7_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !armed_q |-> (ticks_q == '0));
   a_r12_cancel_stops: assert property (@(posedge clk) disable iff (!rst_n)
      (cancel && !restart) |=> !expire);

endmodule

// File: rtl/rx_trig_fifo.sv
module rx_trig_fifo #(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned DEPTH     = 16,
   parameter int unsigned TMO_CHARS = 15,
   localparam int unsigned CNT_W    = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_en,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   input  logic              char_tick,
   input  logic              rd_strobe,
   output logic [DATA_W-1:0] rd_data,
   output logic [CNT_W-1:0]  fill_count,
   input  logic              fifo_clr,
   input  logic [1:0]        trig_sel,
   input  logic              rx_irq_en,
   output logic              data_full,
   output logic              rx_irq
);
   import rx_trig_fifo_pkg::*;

   generate
      if (DEPTH < MAX_TRIG) begin : g_bad_depth
         $error("DEPTH must cover the largest threshold");
      end
      if (TMO_CHARS < 2) begin : g_bad_tmo
         $error("TMO_CHARS must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0]  count_q, cnt_nxt, lvl;
   logic              push, pop, expire;
   logic              flag_q, irq_q;
   logic              hit, flag_set, flag_drop;
   logic [DATA_W-1:0] tail_data;

   assign lvl     = CNT_W'(trig_level(trig_sel));
   assign push    = in_valid && rx_en && !fifo_clr && (count_q < CNT_W'(DEPTH));
   assign pop     = rd_strobe && !fifo_clr && (count_q != '0);
   assign cnt_nxt = count_q + CNT_W'(push) - CNT_W'(pop);

   assign hit       = push && (cnt_nxt >= lvl);
   assign flag_set  = hit || expire;
   assign flag_drop = pop && (cnt_nxt < lvl) && !flag_set;

   rx_trig_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (fifo_clr),
      .push     (push),
      .pop      (pop),
      .wdata    (in_data),
      .tail_data(tail_data)
   );

   rx_trig_timer #(.LIMIT(TMO_CHARS)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .restart(push && (cnt_nxt < lvl)),
      .cancel (fifo_clr || (hit && rx_irq_en)),
      .tick   (char_tick),
      .expire (expire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q <= '0;
         flag_q  <= 1'b0;
         irq_q   <= 1'b0;
      end else if (fifo_clr) begin
         count_q <= '0;
         flag_q  <= 1'b0;
         irq_q   <= 1'b0;
      end else begin
         count_q <= cnt_nxt;
         if (flag_set)       flag_q <= 1'b1;
         else if (flag_drop) flag_q <= 1'b0;
         if (!rx_irq_en)     irq_q <= 1'b0;
         else if (flag_set)  irq_q <= 1'b1;
         else if (flag_drop) irq_q <= 1'b0;
      end
   end

   assign rd_data    = (count_q != '0) ? tail_data : '0;
   assign fill_count = count_q;
   assign data_full  = flag_q;
   assign rx_irq     = irq_q;

   a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      count_q <= CNT_W'(DEPTH));
   a_r3_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (count_q == CNT_W'(DEPTH) && !rd_strobe && !fifo_clr) |=> (count_q == CNT_W'(DEPTH)));
   a_r4_disabled_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_en && !rd_strobe && !fifo_clr) |=> $stable(count_q));
   a_r8_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_irq_en |=> !rx_irq);
   a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_clr |=> (count_q == '0 && !data_full && !rx_irq));
   a_r10_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
      (count_q == '0 && !in_valid && !fifo_clr) |=> (count_q == '0 && rd_data == '0));
   a_r11_pushpop: assert property (@(posedge clk) disable iff (!rst_n)
      (push && pop) |=> $stable(count_q));
   a_r5_flag_at_level: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && rx_en && !fifo_clr && !rd_strobe && count_q < CNT_W'(DEPTH)
       && count_q + 1'b1 >= lvl) |=> data_full);

endmodule

// File: tb/rx_trig_fifo_bench.sv
module rx_trig_fifo_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_en = 1'b1;
   logic       in_valid = 1'b0;
   logic [7:0] in_data = '0;
   logic       char_tick = 1'b0;
   logic       rd_strobe = 1'b0;
   logic [7:0] rd_data;
   logic [4:0] fill_count;
   logic       fifo_clr = 1'b0;
   logic [1:0] trig_sel = 2'd0;
   logic       rx_irq_en = 1'b0;
   logic       data_full;
   logic       rx_irq;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   rx_trig_fifo u_rx_trig_fifo (
      .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .in_valid(in_valid),
      .in_data(in_data), .char_tick(char_tick), .rd_strobe(rd_strobe),
      .rd_data(rd_data), .fill_count(fill_count), .fifo_clr(fifo_clr),
      .trig_sel(trig_sel), .rx_irq_en(rx_irq_en), .data_full(data_full),
      .rx_irq(rx_irq)
   );

   typedef struct packed {
      logic       push;
      logic [7:0] din;
      logic       rd;
      logic [4:0] cnt;
      logic       full;
      logic [7:0] dout;
   } vec_t;

   // trig_sel = 1 (level 4), interrupt enabled: rx_irq is expected to track full
   localparam vec_t VECS [12] = '{
      '{1'b1, 8'hA1, 1'b0, 5'd1, 1'b0, 8'hA1},
      '{1'b1, 8'hB2, 1'b0, 5'd2, 1'b0, 8'hA1},
      '{1'b1, 8'hC3, 1'b0, 5'd3, 1'b0, 8'hA1},
      '{1'b1, 8'hD4, 1'b0, 5'd4, 1'b1, 8'hA1},
      '{1'b0, 8'h00, 1'b1, 5'd3, 1'b0, 8'hB2},
      '{1'b1, 8'hE5, 1'b1, 5'd3, 1'b0, 8'hC3},
      '{1'b1, 8'hF6, 1'b0, 5'd4, 1'b1, 8'hC3},
      '{1'b0, 8'h00, 1'b1, 5'd3, 1'b0, 8'hD4},
      '{1'b0, 8'h00, 1'b1, 5'd2, 1'b0, 8'hE5},
      '{1'b0, 8'h00, 1'b1, 5'd1, 1'b0, 8'hF6},
      '{1'b0, 8'h00, 1'b1, 5'd0, 1'b0, 8'h00},
      '{1'b0, 8'h00, 1'b1, 5'd0, 1'b0, 8'h00}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic cycle(input logic v, input logic [7:0] d, input logic r, input logic t);
      in_valid = v; in_data = d; rd_strobe = r; char_tick = t;
      @(negedge clk);
      in_valid = 1'b0; rd_strobe = 1'b0; char_tick = 1'b0;
   endtask

   task automatic clear();
      fifo_clr = 1'b1;
      @(negedge clk);
      fifo_clr = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++; n_chk++;
         $display("FAIL watchdog: actual running expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 count", fill_count, 0);
      chk("R1 full", data_full, 0);
      chk("R1 irq", rx_irq, 0);
      chk("R1 rd_data", rd_data, 0);

      // Table walk: R2 order, R5 level 4, R6 drop, R11 push+pop, R10 empty read
      trig_sel = 2'd1; rx_irq_en = 1'b1;
      for (int i = 0; i < 12; i++) begin
         cycle(VECS[i].push, VECS[i].din, VECS[i].rd, 1'b0);
         chk("R2/R11 count", fill_count, VECS[i].cnt);
         chk("R5/R6 full", data_full, VECS[i].full);
         chk("R8 irq", rx_irq, VECS[i].full);
         chk("R2/R10 rd_data", rd_data, VECS[i].dout);
      end

      // R5 every threshold
      rx_irq_en = 1'b0;
      for (int s = 0; s < 4; s++) begin
         int lv;
         lv = (s == 0) ? 1 : (s == 1) ? 4 : (s == 2) ? 8 : 14;
         clear();
         trig_sel = 2'(s);
         for (int k = 0; k < lv - 1; k++) cycle(1'b1, 8'(k), 1'b0, 1'b0);
         chk("R5 below level", data_full, 0);
         cycle(1'b1, 8'h55, 1'b0, 1'b0);
         chk("R5 at level", data_full, 1);
         chk("R8 irq off", rx_irq, 0);
      end

      // R2 wraparound and R3 overflow
      clear();
      trig_sel = 2'd3;
      for (int k = 0; k < 10; k++) cycle(1'b1, 8'h10 + 8'(k), 1'b0, 1'b0);
      for (int k = 0; k < 10; k++) cycle(1'b0, 8'h00, 1'b1, 1'b0);
      for (int k = 0; k < 16; k++) cycle(1'b1, 8'h40 + 8'(k), 1'b0, 1'b0);
      chk("R3 full count", fill_count, 16);
      cycle(1'b1, 8'hEE, 1'b0, 1'b0);
      chk("R3 drop", fill_count, 16);
      for (int k = 0; k < 16; k++) begin
         chk("R2 wrap order", rd_data, 8'h40 + 8'(k));
         cycle(1'b0, 8'h00, 1'b1, 1'b0);
      end
      chk("R3 no extra byte", fill_count, 0);

      // R4 receiver disabled
      rx_en = 1'b0;
      cycle(1'b1, 8'h77, 1'b0, 1'b0);
      chk("R4 ignored", fill_count, 0);
      rx_en = 1'b1;

      // R7 timeout at fifteenth tick, with restart
      clear();
      trig_sel = 2'd3; rx_irq_en = 1'b1;
      cycle(1'b1, 8'h01, 1'b0, 1'b0);
      for (int k = 0; k < 10; k++) cycle(1'b0, 8'h00, 1'b0, 1'b1);
      cycle(1'b1, 8'h02, 1'b0, 1'b0);
      for (int k = 0; k < 14; k++) cycle(1'b0, 8'h00, 1'b0, 1'b1);
      chk("R7 after 14 ticks", data_full, 0);
      cycle(1'b0, 8'h00, 1'b0, 1'b1);
      chk("R7 after 15 ticks", data_full, 1);
      chk("R8 irq on timeout", rx_irq, 1);
      rx_irq_en = 1'b0;
      cycle(1'b0, 8'h00, 1'b0, 1'b0);
      chk("R8 irq disabled", rx_irq, 0);
      chk("R8 flag kept", data_full, 1);

      // R12 threshold hit cancels timer
      clear();
      trig_sel = 2'd1; rx_irq_en = 1'b1;
      for (int k = 0; k < 4; k++) cycle(1'b1, 8'h20 + 8'(k), 1'b0, 1'b0);
      chk("R12 hit", data_full, 1);
      cycle(1'b0, 8'h00, 1'b1, 1'b0);
      chk("R6 drop below", data_full, 0);
      chk("R8 irq drops", rx_irq, 0);
      for (int k = 0; k < 16; k++) cycle(1'b0, 8'h00, 1'b0, 1'b1);
      chk("R12 no late timeout", data_full, 0);

      // R9 clear overrides push and read
      cycle(1'b1, 8'h30, 1'b0, 1'b0);
      chk("R9 setup", data_full, 1);
      fifo_clr = 1'b1;
      cycle(1'b1, 8'h31, 1'b1, 1'b0);
      fifo_clr = 1'b0;
      chk("R9 count", fill_count, 0);
      chk("R9 full", data_full, 0);
      chk("R9 irq", rx_irq, 0);
      chk("R9 rd_data", rd_data, 0);

      // R10 empty read
      cycle(1'b0, 8'h00, 1'b1, 1'b0);
      chk("R10 count", fill_count, 0);
      chk("R10 rd_data", rd_data, 0);
      cycle(1'b1, 8'h9A, 1'b0, 1'b0);
      chk("R10 next byte", rd_data, 8'h9A);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule